// File: doc/BRIEF.md
# Daisy-Chain Bus Arbitration Relay

This block sits between a system bus arbiter and one further bus master placed downstream of it. It merges the downstream master's request with its own internal request into a single request towards the arbiter. When the arbiter answers with a grant, the relay keeps the bus for itself if its internal requester is waiting. Otherwise it hands the grant on to the downstream master.

In normal operation both relayed paths pass through one register, so each adds one clock of delay. While the sleep input is high, both paths become combinational: downstream request to arbiter request, and arbiter grant to downstream grant. A mode input sets the pin polarity. All four arbitration pins are active low in the default mode and active high in the alternate local-bus mode. A chain-enable input decides whether a downstream master is attached at all.

Once the internal request is raised, it is held until the arbiter grants. A stop, a software reset or sleep arriving in the meantime does not withdraw it.

Top module: `arb_relay`

## Requirements
- R1: After the synchronous reset `rst`, and with `sleep` low, the arbiter request pin and the downstream grant pin are at their inactive level, and `bus_owned` is 0.
- R2: With `alt_mode`=0, the pins `arb_req_pin`, `arb_gnt_pin`, `dn_req_pin` and `dn_gnt_pin` are active when 0. With `alt_mode`=1 they are active when 1.
- R3: If `int_req` is 1 while `stop_req`, `soft_rst` and `sleep` are all 0, the arbiter request becomes active at the next clock edge. It is not active before that edge.
- R4: Once the internal request is active, it stays active until the arbiter grant is active. This holds even if `int_req` drops and `stop_req`, `soft_rst` or `sleep` rise.
- R5: If the arbiter grant is active while the internal request is held, `bus_owned` rises at the next edge and the grant is not passed downstream. Ownership and the arbiter request stay active while both the grant and `int_req` remain active. Ownership ends at the edge after `int_req` drops.
- R6: With `sleep` low and `chain_en` high, the downstream grant follows the arbiter grant one clock later. This applies only while the relay has no internal request and owns no bus.
- R7: With `sleep` low and `chain_en` high, the downstream request reaches the arbiter request one clock later.
- R8: With `sleep` high and `chain_en` high, the downstream request reaches the arbiter request, and the arbiter grant reaches the downstream grant, in the same cycle.
- R9: With `chain_en` low, the downstream grant pin is held inactive, and the downstream request pin has no effect on the arbiter request.
- R10: If no internal request is held, `int_req` raises no request while any of `stop_req`, `soft_rst` or `sleep` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| alt_mode | input | 1 | 0: pins active low; 1: pins active high |
| chain_en | input | 1 | Downstream master attached |
| sleep | input | 1 | Selects the combinational bypass |
| int_req | input | 1 | Internal bus request, active high |
| stop_req | input | 1 | Stop condition; blocks new internal requests |
| soft_rst | input | 1 | Software reset; blocks new internal requests |
| arb_gnt_pin | input | 1 | Grant from the system arbiter |
| dn_req_pin | input | 1 | Request from the downstream master |
| arb_req_pin | output | 1 | Combined request to the system arbiter |
| dn_gnt_pin | output | 1 | Grant forwarded to the downstream master |
| bus_owned | output | 1 | Relay currently owns the bus, active high |

## Verification
A corrupted hold register shows up on the arbiter request pin at the next edge, either as a request dropped before the grant or as one that never rises. A stuck relay stage shows up one clock after the stimulus changes, as a downstream grant or arbiter request that lags, leads or never toggles. A wrong ownership state either forwards the grant downstream while `bus_owned` is high, or fails to forward it one clock after ownership ends. Both are visible within two edges of the grant.

// File: rtl/arb_relay_pkg.sv
package arb_relay_pkg;
  // Pin level for an active-high internal value; the default mode is active low.
  function automatic logic act_to_pin(input logic act, input logic alt);
    return alt ? act : ~act;
  endfunction

  // Active-high internal value for a pin level.
  function automatic logic pin_to_act(input logic pin, input logic alt);
    return alt ? pin : ~pin;
  endfunction
endpackage

// File: rtl/relay_stage.sv
module relay_stage #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         bypass,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] d_q;

  always_ff @(posedge clk) begin
    if (rst) d_q <= '0;
    else     d_q <= d;
  end

  assign q = bypass ? d : d_q;
endmodule

// File: rtl/relay_own_ctl.sv
module relay_own_ctl (
  input  logic clk,
  input  logic rst,
  input  logic int_req,
  input  logic cancel,
  input  logic gnt_act,
  output logic req_hold,
  output logic own_q
);
  logic hold_n, own_n;

  always_comb begin
    if (req_hold) hold_n = ~gnt_act;
    else          hold_n = int_req & ~cancel & ~own_q;
    own_n = gnt_act & (own_q ? int_req : req_hold);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      req_hold <= 1'b0;
      own_q    <= 1'b0;
    end else begin
      req_hold <= hold_n;
      own_q    <= own_n;
    end
  end
endmodule

// File: rtl/arb_relay.sv
module arb_relay
  import arb_relay_pkg::*;
#(
  parameter int CHAIN_W = 1
) (
  input  logic clk,
  input  logic rst,
  input  logic alt_mode,
  input  logic chain_en,
  input  logic sleep,
  input  logic int_req,
  input  logic stop_req,
  input  logic soft_rst,
  input  logic arb_gnt_pin,
  input  logic dn_req_pin,
  output logic arb_req_pin,
  output logic dn_gnt_pin,
  output logic bus_owned
);
  // Internal events, named for the checker
  logic gnt_act, dn_req_act, arb_req_act, dn_gnt_act;
  logic req_hold, own_q, int_active, cancel;
  logic [CHAIN_W-1:0] fwd_now, fwd_out, dreq_now, dreq_out;

  assign gnt_act    = pin_to_act(arb_gnt_pin, alt_mode);
  assign dn_req_act = pin_to_act(dn_req_pin, alt_mode);
  assign cancel     = stop_req | soft_rst | sleep;

  relay_own_ctl u_own (
    .clk(clk), .rst(rst), .int_req(int_req), .cancel(cancel),
    .gnt_act(gnt_act), .req_hold(req_hold), .own_q(own_q)
  );

  assign int_active = req_hold | own_q;
  assign fwd_now    = {CHAIN_W{gnt_act & ~int_active}};
  assign dreq_now   = {CHAIN_W{chain_en & dn_req_act}};

  relay_stage #(.W(CHAIN_W)) u_gnt_stage (
    .clk(clk), .rst(rst), .bypass(sleep), .d(fwd_now), .q(fwd_out)
  );

  relay_stage #(.W(CHAIN_W)) u_req_stage (
    .clk(clk), .rst(rst), .bypass(sleep), .d(dreq_now), .q(dreq_out)
  );

  assign dn_gnt_act  = chain_en & fwd_out[0];
  assign arb_req_act = int_active | dreq_out[0];

  assign arb_req_pin = act_to_pin(arb_req_act, alt_mode);
  assign dn_gnt_pin  = act_to_pin(dn_gnt_act, alt_mode);
  assign bus_owned   = own_q;
endmodule

// File: rtl/arb_relay_chk.sv
module arb_relay_chk (
  input logic clk,
  input logic rst,
  input logic sleep,
  input logic chain_en,
  input logic gnt_act,
  input logic dn_req_act,
  input logic arb_req_act,
  input logic dn_gnt_act,
  input logic int_active,
  input logic req_hold,
  input logic own_q
);
  logic armed = 1'b0;

  always_ff @(posedge clk) armed <= ~rst;

  assert_own_blocks_fwd_R5: assert property (@(posedge clk) disable iff (rst)
    own_q |-> !dn_gnt_act);

  assert_chain_off_R9: assert property (@(posedge clk) disable iff (rst)
    !chain_en |-> !dn_gnt_act);

  assert_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (armed && $past(req_hold) && !$past(gnt_act)) |-> req_hold);

  assert_gnt_delay_R6: assert property (@(posedge clk) disable iff (rst)
    (armed && !sleep && chain_en) |-> (dn_gnt_act == $past(gnt_act && !int_active)));

  assert_req_delay_R7: assert property (@(posedge clk) disable iff (rst)
    (armed && !sleep) |-> (arb_req_act == (int_active || $past(chain_en && dn_req_act))));

  assert_bypass_R8: assert property (@(posedge clk) disable iff (rst)
    (sleep && chain_en) |-> (arb_req_act == (int_active || dn_req_act)));
endmodule

bind arb_relay arb_relay_chk u_chk (
  .clk(clk), .rst(rst), .sleep(sleep), .chain_en(chain_en),
  .gnt_act(gnt_act), .dn_req_act(dn_req_act), .arb_req_act(arb_req_act),
  .dn_gnt_act(dn_gnt_act), .int_active(int_active), .req_hold(req_hold),
  .own_q(own_q)
);

// File: tb/test_arb_relay.sv
module test_arb_relay;
  localparam int PERIOD = 10;

  logic clk = 1'b0;
  logic rst = 1'b1, alt = 1'b0, chain_en = 1'b0, sleep = 1'b0;
  logic int_req = 1'b0, stop_req = 1'b0, soft_rst = 1'b0;
  logic gnt_a = 1'b0, dnreq_a = 1'b0;
  logic arb_gnt_pin, dn_req_pin, arb_req_pin, dn_gnt_pin, bus_owned;
  int total = 0, bad = 0;
  bit done = 1'b0;

  always #(PERIOD/2) clk = ~clk;

  // R2: bench-side polarity, active low unless alt is set
  assign arb_gnt_pin = alt ? gnt_a : ~gnt_a;
  assign dn_req_pin  = alt ? dnreq_a : ~dnreq_a;

  arb_relay i_arb_relay (
    .clk(clk), .rst(rst), .alt_mode(alt), .chain_en(chain_en), .sleep(sleep),
    .int_req(int_req), .stop_req(stop_req), .soft_rst(soft_rst),
    .arb_gnt_pin(arb_gnt_pin), .dn_req_pin(dn_req_pin),
    .arb_req_pin(arb_req_pin), .dn_gnt_pin(dn_gnt_pin), .bus_owned(bus_owned)
  );

  function automatic logic act(input logic pin);
    return alt ? pin : ~pin;
  endfunction

  task automatic tick();
    @(posedge clk);
    #(PERIOD/4);
  endtask

  task automatic chk(input string req, input logic got, input logic exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got=%0b expected=%0b", req, got, exp);
    end
  endtask

  task automatic t_reset();
    rst = 1'b1; tick(); tick(); rst = 1'b0; #1;
    chk("R1 req pin high", arb_req_pin, 1'b1);
    chk("R1 dn gnt pin high", dn_gnt_pin, 1'b1);
    chk("R1 owned", bus_owned, 1'b0);
  endtask

  task automatic t_polarity();
    alt = 1'b1; #1;
    chk("R2 alt req pin idle low", arb_req_pin, 1'b0);
    chk("R2 alt gnt pin idle low", dn_gnt_pin, 1'b0);
    chain_en = 1'b1; dnreq_a = 1'b1; tick();
    chk("R2 alt req pin active high", arb_req_pin, 1'b1);
    dnreq_a = 1'b0; tick();
    alt = 1'b0; #1;
    chk("R2 default req pin idle high", arb_req_pin, 1'b1);
  endtask

  task automatic t_fwd();
    chain_en = 1'b1; gnt_a = 1'b1; #1;
    chk("R6 no gnt before edge", act(dn_gnt_pin), 1'b0);
    tick();
    chk("R6 gnt after one edge", act(dn_gnt_pin), 1'b1);
    gnt_a = 1'b0; #1;
    chk("R6 gnt held until edge", act(dn_gnt_pin), 1'b1);
    tick();
    chk("R6 gnt drops after edge", act(dn_gnt_pin), 1'b0);
  endtask

  task automatic t_dnreq();
    dnreq_a = 1'b1; #1;
    chk("R7 req not before edge", act(arb_req_pin), 1'b0);
    tick();
    chk("R7 req after one edge", act(arb_req_pin), 1'b1);
    dnreq_a = 1'b0; tick();
    chk("R7 req drops", act(arb_req_pin), 1'b0);
  endtask

  task automatic t_sleep();
    sleep = 1'b1; dnreq_a = 1'b1; #1;
    chk("R8 req bypass", act(arb_req_pin), 1'b1);
    gnt_a = 1'b1; #1;
    chk("R8 gnt bypass", act(dn_gnt_pin), 1'b1);
    dnreq_a = 1'b0; gnt_a = 1'b0; #1;
    chk("R8 req bypass off", act(arb_req_pin), 1'b0);
    chk("R8 gnt bypass off", act(dn_gnt_pin), 1'b0);
    sleep = 1'b0; tick();
  endtask

  task automatic t_chain_off();
    chain_en = 1'b0; dnreq_a = 1'b1; tick(); tick();
    chk("R9 dn req ignored", act(arb_req_pin), 1'b0);
    gnt_a = 1'b1; tick();
    chk("R9 dn gnt held off", act(dn_gnt_pin), 1'b0);
    sleep = 1'b1; #1;
    chk("R9 dn gnt off in sleep", act(dn_gnt_pin), 1'b0);
    chk("R9 dn req ignored in sleep", act(arb_req_pin), 1'b0);
    sleep = 1'b0; gnt_a = 1'b0; dnreq_a = 1'b0; chain_en = 1'b1; tick(); tick();
  endtask

  task automatic t_internal();
    int_req = 1'b1; #1;
    chk("R3 no req before edge", act(arb_req_pin), 1'b0);
    tick();
    chk("R3 req after edge", act(arb_req_pin), 1'b1);
    int_req = 1'b0; stop_req = 1'b1; soft_rst = 1'b1; sleep = 1'b1;
    tick(); tick(); tick();
    chk("R4 req held through cancels", act(arb_req_pin), 1'b1);
    stop_req = 1'b0; soft_rst = 1'b0; sleep = 1'b0; int_req = 1'b1; gnt_a = 1'b1; #1;
    chk("R5 no forward before edge", act(dn_gnt_pin), 1'b0);
    tick();
    chk("R5 owned", bus_owned, 1'b1);
    chk("R5 grant kept", act(dn_gnt_pin), 1'b0);
    tick();
    chk("R5 still owned", bus_owned, 1'b1);
    chk("R5 req while owning", act(arb_req_pin), 1'b1);
    chk("R5 grant still kept", act(dn_gnt_pin), 1'b0);
    int_req = 1'b0; tick();
    chk("R5 release", bus_owned, 1'b0);
    chk("R5 no forward on release edge", act(dn_gnt_pin), 1'b0);
    tick();
    chk("R6 forward after release", act(dn_gnt_pin), 1'b1);
    gnt_a = 1'b0; tick(); tick();
  endtask

  task automatic t_cancel();
    stop_req = 1'b1; int_req = 1'b1; tick(); tick();
    chk("R10 stop blocks", act(arb_req_pin), 1'b0);
    stop_req = 1'b0; soft_rst = 1'b1; tick(); tick();
    chk("R10 soft reset blocks", act(arb_req_pin), 1'b0);
    soft_rst = 1'b0; sleep = 1'b1; tick(); tick();
    chk("R10 sleep blocks", act(arb_req_pin), 1'b0);
    int_req = 1'b0; sleep = 1'b0; tick();
  endtask

  initial begin
    #(PERIOD/4);
    t_reset();
    t_polarity();
    t_fwd();
    t_dnreq();
    t_sleep();
    t_chain_off();
    t_internal();
    t_cancel();
    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #(PERIOD*20000);
    if (!done) begin
      done = 1'b1;
      total++; bad++;
      $display("FAIL watchdog: got=hang expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule